// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox

The block lets processors on one chip hand short fixed-size messages to one another. It holds a parameterised set of one-way channels (32 by default). Each channel has its own 64-byte register window on a simple 32-bit register bus. A sender claims an idle channel by writing its own one-hot vector to the owner register and reading it back. It then picks a destination vector, fills eight data words and fires the channel with its own bit. The destination's interrupt line then rises, unless its mask bit is set.

The receiver reads the data and clears its pending bit. In auto-acknowledge mode that clear also marks the channel as acknowledged, and the owner can then hand the channel back by writing its own bit to the owner register a second time. A single global lock guards every channel register against writes. The lock opens only on a fixed key and closes again on any other value written to it.

Top module: `mailbox_hub`

## Requirements
- R1: After reset every channel reads idle: its mode register reads 0x10. All interrupt outputs are low, every mask register reads 0xFFFFFFFF, and the lock register at 0xA00 reads 1 (locked).
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the block, after which that register reads 0. Writing any other value there locks it again, and it then reads 1.
- R3: While locked, writes to every channel register have no effect, and reads return the current contents.
- R4: Writing a nonzero value to the owner register (offset 0x00) of an idle channel stores it. The channel then stops being idle, so bit 4 of the mode register (offset 0x10) reads 0.
- R5: A write to the owner register of a channel that is not idle is ignored, unless it is the release case of R9.
- R6: Writing a value equal to the stored owner to the send register (offset 0x1C) ORs the destination register (offset 0x04) into the pending register (offset 0x0C) and clears the ack bit. A send with any other value is ignored.
- R7: Interrupt output bit v is the OR, over all channels, of pending bit v AND NOT mask bit v. The mask register is at offset 0x14.
- R8: Writing a vector to destination-clear (offset 0x08) clears those pending bits. If auto-ack is enabled (mode bit 0) and any cleared bit was pending, mode bit 7 (ack) becomes 1. With auto-ack off, the ack bit does not change.
- R9: With ack set, writing the stored owner value to the owner register releases the channel: owner, destination, mode and pending all become 0, and the mode register reads 0x10.
- R10: Eight data words at offsets 0x20 + 4*i (i = 0..7) store and return 32-bit values.
- R11: Channel c's window starts at c*0x40. Reads at addresses beyond the last channel window, other than 0xA00, return 0.
- R12: Writing a vector to interrupt-clear (offset 0x18) clears those pending bits without setting the ack bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W | Byte address for read and write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from busAddr |
| irqOut | output | VEC_W | One interrupt line per processor vector |

## Verification
The assertions assume that busAddr and busWrData are stable whenever busWrEn is high at a clock edge. They also assume that reset is held for at least one edge before traffic starts. The stimulus drives all bus signals at the falling edge and holds them across the following rising edge. Writes always use word-aligned addresses. Owner, send and destination values are one-hot, as senders are expected to use. A behavioural model in the bench predicts the interrupt vector on every cycle and the read data for every register the bench reads.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MSG_WORDS = 8;
  localparam int WORD_IDX_W = $clog2(MSG_WORDS);
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef enum logic [3:0] {
    RG_SRC, RG_DST, RG_DCLR, RG_DSTAT, RG_MODE, RG_MASK, RG_ICLR, RG_SEND,
    RG_DATA, RG_NONE
  } regId_e;

  typedef struct packed {
    logic                  wr;
    regId_e                regId;
    logic [WORD_IDX_W-1:0] word;
  } chanCmd_t;
endpackage

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int VEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  chanCmd_t         cmd,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic [VEC_W-1:0] irqPend
);
  logic [VEC_W-1:0] ownerQ, dstQ, maskQ, pendQ;
  logic             autoAckQ, ackQ;
  logic [31:0]      dataQ [MSG_WORDS];
  logic [VEC_W-1:0] vecIn;
  logic             idle;

  assign vecIn = wrData[VEC_W-1:0];
  assign idle  = (ownerQ == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ownerQ   <= '0;
      dstQ     <= '0;
      maskQ    <= '1;
      pendQ    <= '0;
      autoAckQ <= 1'b0;
      ackQ     <= 1'b0;
      for (int i = 0; i < MSG_WORDS; i++) dataQ[i] <= '0;
    end else if (we) begin
      unique case (cmd.regId)
        RG_SRC: begin
          if (idle) begin
            ownerQ <= vecIn;
          end else if (ackQ && vecIn == ownerQ) begin
            ownerQ   <= '0;
            dstQ     <= '0;
            pendQ    <= '0;
            autoAckQ <= 1'b0;
            ackQ     <= 1'b0;
          end
        end
        RG_DST:  dstQ <= vecIn;
        RG_DCLR: begin
          pendQ <= pendQ & ~vecIn;
          if (autoAckQ && (pendQ & vecIn) != '0) ackQ <= 1'b1;
        end
        RG_MODE: autoAckQ <= wrData[0];
        RG_MASK: maskQ <= vecIn;
        RG_ICLR: pendQ <= pendQ & ~vecIn;
        RG_SEND: begin
          if (!idle && vecIn == ownerQ) begin
            pendQ <= pendQ | dstQ;
            ackQ  <= 1'b0;
          end
        end
        RG_DATA: dataQ[cmd.word] <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    unique case (cmd.regId)
      RG_SRC:   rdData = 32'(ownerQ);
      RG_DST:   rdData = 32'(dstQ);
      RG_DSTAT: rdData = 32'(pendQ);
      RG_MODE:  rdData = {24'b0, ackQ, 2'b0, idle, 3'b0, autoAckQ};
      RG_MASK:  rdData = 32'(maskQ);
      RG_DATA:  rdData = dataQ[cmd.word];
      default:  rdData = '0;
    endcase
  end

  assign irqPend = pendQ & ~maskQ;
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int          NUM_CH   = 32,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] LOCK_OFS = 12'hA00,
  localparam int         CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int         WIN_W    = ADDR_W - 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output chanCmd_t          cmd,
  output logic [CH_W-1:0]   chIdx,
  output logic              chValid,
  output logic              lockHit,
  output logic              locked
);
  logic [WIN_W-1:0] winIdx;
  logic [3:0]       regOff;

  assign winIdx  = busAddr[ADDR_W-1:6];
  assign regOff  = busAddr[5:2];
  assign lockHit = (busAddr == ADDR_W'(LOCK_OFS)) && (busAddr[1:0] == 2'b00);
  assign chValid = (int'(winIdx) < NUM_CH) && !lockHit;
  assign chIdx   = winIdx[CH_W-1:0];

  always_comb begin
    cmd.wr   = busWrEn && chValid && !locked;
    cmd.word = regOff[WORD_IDX_W-1:0];
    if (regOff[3]) cmd.regId = RG_DATA;
    else begin
      unique case (regOff[2:0])
        3'd0: cmd.regId = RG_SRC;
        3'd1: cmd.regId = RG_DST;
        3'd2: cmd.regId = RG_DCLR;
        3'd3: cmd.regId = RG_DSTAT;
        3'd4: cmd.regId = RG_MODE;
        3'd5: cmd.regId = RG_MASK;
        3'd6: cmd.regId = RG_ICLR;
        default: cmd.regId = RG_SEND;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) locked <= 1'b1;
    else if (busWrEn && lockHit) locked <= (busWrData != UNLOCK_KEY);
  end
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int  NUM_CH = 32,
  parameter int  VEC_W  = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  chanCmd_t         cmd,
  input  logic [CH_W-1:0]  chIdx,
  input  logic             chValid,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic [VEC_W-1:0] irqOut
);
  logic [31:0]      rdArr   [NUM_CH];
  logic [VEC_W-1:0] pendArr [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    logic weCh;
    assign weCh = cmd.wr && (chIdx == CH_W'(c));
    mbox_chan #(.VEC_W(VEC_W)) uChan (
      .clk    (clk),
      .rst    (rst),
      .we     (weCh),
      .cmd    (cmd),
      .wrData (wrData),
      .rdData (rdArr[c]),
      .irqPend(pendArr[c])
    );
  end

  assign rdData = chValid ? rdArr[chIdx] : '0;

  always_comb begin
    irqOut = '0;
    for (int c = 0; c < NUM_CH; c++) irqOut |= pendArr[c];
  end
endmodule

// File: rtl/mailbox_hub.sv
module mailbox_hub
  import mbox_pkg::*;
#(
  parameter int          NUM_CH   = 32,
  parameter int          VEC_W    = 32,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] LOCK_OFS = 12'hA00,
  localparam int         CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [VEC_W-1:0]  irqOut
);
  chanCmd_t        cmd;
  logic [CH_W-1:0] chIdx;
  logic            chValid, lockHit, locked;
  logic [31:0]     dpRd;

  mbox_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .LOCK_OFS(LOCK_OFS)) uCtrl (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .cmd(cmd), .chIdx(chIdx), .chValid(chValid),
    .lockHit(lockHit), .locked(locked)
  );

  mbox_dp #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) uDp (
    .clk(clk), .rst(rst), .cmd(cmd), .chIdx(chIdx), .chValid(chValid),
    .wrData(busWrData), .rdData(dpRd), .irqOut(irqOut)
  );

  assign busRdData = lockHit ? {31'b0, locked} : dpRd;
endmodule

// File: rtl/mailbox_hub_chk.sv
module mailbox_hub_chk #(
  parameter int          NUM_CH   = 32,
  parameter int          VEC_W    = 32,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] LOCK_OFS = 12'hA00
) (
  input logic              clk,
  input logic              rst,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic [VEC_W-1:0]  irqOut,
  input logic              locked
);
  localparam logic [31:0] KEY = 32'h1ACCE551;
  logic lockAddr, beyondWin;
  assign lockAddr  = (busAddr == ADDR_W'(LOCK_OFS));
  assign beyondWin = (int'(busAddr[ADDR_W-1:6]) >= NUM_CH) && !lockAddr;

  always @(negedge clk) begin
    if (rst) begin
      a_r1_reset_quiet: assert (irqOut == '0 && locked);
    end
  end

  a_r2_key_opens: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && lockAddr && busWrData == KEY) |=> !locked);

  a_r2_other_closes: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && lockAddr && busWrData != KEY) |=> locked);

  a_r3_locked_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && locked && !lockAddr) |=> $stable(irqOut));

  a_r11_beyond_zero: assert property (@(posedge clk) disable iff (rst)
    beyondWin |-> busRdData == 32'd0);
endmodule

bind mailbox_hub mailbox_hub_chk #(
  .NUM_CH(NUM_CH), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .LOCK_OFS(LOCK_OFS)
) uChk (
  .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut),
  .locked(locked)
);

// File: tb/sim_mailbox_hub.sv
`timescale 1ns/1ps
module sim_mailbox_hub;
  localparam int NCH = 32;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mailbox_hub u0 (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  // behavioural reference
  logic [31:0] mSrc [NCH], mDst [NCH], mMask [NCH], mPend [NCH];
  logic [31:0] mData [NCH][8];
  bit mAuto [NCH], mAck [NCH];
  bit mLocked;

  task automatic mReset();
    for (int c = 0; c < NCH; c++) begin
      mSrc[c] = 0; mDst[c] = 0; mMask[c] = '1; mPend[c] = 0;
      mAuto[c] = 0; mAck[c] = 0;
      for (int w = 0; w < 8; w++) mData[c][w] = 0;
    end
    mLocked = 1;
  endtask

  task automatic mWrite(input int a, input logic [31:0] d);
    int c, off;
    if (a == 'hA00) begin mLocked = (d != KEY); return; end
    c = a / 64;
    off = (a % 64) / 4;
    if (c >= NCH || mLocked) return;
    if (off >= 8) begin mData[c][off-8] = d; return; end
    case (off)
      0: if (mSrc[c] == 0) mSrc[c] = d;
         else if (mAck[c] && d == mSrc[c]) begin
           mSrc[c] = 0; mDst[c] = 0; mPend[c] = 0; mAuto[c] = 0; mAck[c] = 0;
         end
      1: mDst[c] = d;
      2: begin
           if (mAuto[c] && (mPend[c] & d) != 0) mAck[c] = 1;
           mPend[c] = mPend[c] & ~d;
         end
      4: mAuto[c] = d[0];
      5: mMask[c] = d;
      6: mPend[c] = mPend[c] & ~d;
      7: if (mSrc[c] != 0 && d == mSrc[c]) begin
           mPend[c] = mPend[c] | mDst[c]; mAck[c] = 0;
         end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] mRead(input int a);
    int c, off;
    if (a == 'hA00) return {31'b0, mLocked};
    c = a / 64;
    off = (a % 64) / 4;
    if (c >= NCH) return 0;
    if (off >= 8) return mData[c][off-8];
    case (off)
      0: return mSrc[c];
      1: return mDst[c];
      3: return mPend[c];
      4: return (mAck[c] ? 32'h80 : 0) | (mSrc[c] == 0 ? 32'h10 : 0) | (mAuto[c] ? 1 : 0);
      5: return mMask[c];
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mIrq();
    logic [31:0] v = 0;
    for (int c = 0; c < NCH; c++) v |= mPend[c] & ~mMask[c];
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R7: interrupt vector compared against the model every cycle
  always @(negedge clk) if (!rst && !done) check("R7 irq", irqOut, mIrq());

  task automatic wr(input int a, input logic [31:0] d);
    busAddr = 12'(a); busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    mWrite(a, d);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input int a);
    busAddr = 12'(a);
    #1;
    check(tag, busRdData, mRead(a));
  endtask

  task automatic rdExp(input string tag, input int a, input logic [31:0] exp);
    busAddr = 12'(a);
    #1;
    check(tag, busRdData, exp);
    check({tag, " model"}, mRead(a), exp);
  endtask

  localparam int C3 = 3 * 64;
  localparam int C31 = 31 * 64;

  initial begin
    mReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rdExp("R1 mode ch0", 'h10, 32'h10);
    rdExp("R1 mode ch31", C31 + 'h10, 32'h10);
    rdExp("R1 mask ch5", 5*64 + 'h14, 32'hFFFF_FFFF);
    rdExp("R1 lock", 'hA00, 32'h1);
    check("R1 irq", irqOut, 32'h0);

    // R3 locked writes ignored
    wr(C3, 32'h4);
    rdExp("R3 src locked", C3, 32'h0);
    wr(C3 + 'h14, 32'h0);
    rdExp("R3 mask locked", C3 + 'h14, 32'hFFFF_FFFF);

    // R2 key behaviour
    wr('hA00, KEY);
    rdExp("R2 unlocked", 'hA00, 32'h0);
    wr('hA00, 32'h1234);
    rdExp("R2 relocked", 'hA00, 32'h1);
    wr('hA00, KEY);

    // R4 acquire
    wr(C3, 32'h4);
    rdExp("R4 owner", C3, 32'h4);
    rdExp("R4 mode busy", C3 + 'h10, 32'h0);

    // R5 foreign claim ignored
    wr(C3, 32'h20);
    rdExp("R5 owner kept", C3, 32'h4);

    // R10 data words
    for (int i = 0; i < 8; i++) wr(C3 + 'h20 + 4*i, 32'hA5000000 + i*32'h01010101);
    for (int i = 0; i < 8; i++) rd("R10 data", C3 + 'h20 + 4*i);
    rdExp("R10 word7", C3 + 'h3C, 32'hAC070707);

    // R6 send
    wr(C3 + 'h14, ~32'h200);
    wr(C3 + 'h04, 32'h200);
    wr(C3 + 'h10, 32'h1);
    wr(C3 + 'h1C, 32'h20);
    check("R6 wrong sender", irqOut, 32'h0);
    wr(C3 + 'h1C, 32'h4);
    check("R6 irq raised", irqOut, 32'h200);
    rdExp("R6 pending", C3 + 'h0C, 32'h200);

    // R7 masking
    wr(C3 + 'h14, 32'hFFFF_FFFF);
    check("R7 masked", irqOut, 32'h0);
    wr(C3 + 'h14, ~32'h200);
    check("R7 unmasked", irqOut, 32'h200);

    // R9 release refused before ack
    wr(C3, 32'h4);
    rdExp("R9 no release w/o ack", C3, 32'h4);

    // R8 auto-ack clear
    wr(C3 + 'h08, 32'h200);
    check("R8 irq dropped", irqOut, 32'h0);
    rdExp("R8 mode ack", C3 + 'h10, 32'h81);

    // R9 release
    wr(C3, 32'h4);
    rdExp("R9 mode idle", C3 + 'h10, 32'h10);
    rdExp("R9 owner clr", C3, 32'h0);
    rdExp("R9 dst clr", C3 + 'h04, 32'h0);

    // R12 and R8 manual mode on last channel, plus two channels at once
    wr(C31, 32'h2);
    wr(C31 + 'h14, 32'h0);
    wr(C31 + 'h04, 32'h0010_0000);
    wr(C31 + 'h1C, 32'h2);
    check("R11 ch31 irq", irqOut, 32'h0010_0000);
    wr(0, 32'h8);
    wr('h14, ~32'h1);
    wr('h04, 32'h1);
    wr('h1C, 32'h8);
    check("R7 two channels", irqOut, 32'h0010_0001);
    wr(C31 + 'h18, 32'h0010_0000);
    check("R12 iclr", irqOut, 32'h1);
    rdExp("R12 no ack", C31 + 'h10, 32'h0);
    wr(C31 + 'h1C, 32'h2);
    wr(C31 + 'h08, 32'h0010_0000);
    rdExp("R8 manual no ack", C31 + 'h10, 32'h0);
    wr(C31, 32'h2);
    rdExp("R5 still owned", C31, 32'h2);

    // R3 reads still work while locked
    wr('hA00, 32'h0);
    wr('h14, 32'hFFFF_FFFF);
    check("R3 irq kept", irqOut, 32'h1);
    rdExp("R3 read locked", 'h14, ~32'h1);

    // R11 beyond last window
    rdExp("R11 ch32", 'h800, 32'h0);
    rdExp("R11 ch36", 'h900, 32'h0);

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule